// File: doc/BRIEF.md
# Two-Copy Hot-Unit Rotation Controller

This controller chooses which of two functionally identical copies of a heavily used datapath unit does the work. At any moment exactly one copy is active and clocked while the other rests and cools. A rotation is started either when a programmable cycle budget runs out or when the active copy's temperature alarm rises. The cooler copy then takes over, so heat is spread across two places on the die.

Every rotation follows the same handover sequence. New issue is stalled, the pipeline drains until it reports empty, and an external state-transfer engine is told to copy the architectural state into the resting copy. When the engine reports done, one final cycle moves activity, clock enable and the operand-routing select to the other copy and then lifts the stall. A delayed copy of the select is provided for a unit shared between the copies, because the longer wires to that unit add one cycle of latency.

Top module: `am_pingpong_ctrl`

## Requirements
- R1: After reset: sel_o=0, act_o=2'b01, clken_o=2'b01, shared_sel_o=0, stall_o=0, busy_o=0, copy_start_o=0, mig_count_o=0.
- R2: act_o is always one-hot, with bit i set when copy i is active. It equals 1<<sel_o and changes only when a rotation completes.
- R3: With mode_i=2'b00 (periodic) or 2'b10 (both), a nonzero period_i makes the controller leave RUN after period_i RUN cycles, counted from reset or from the end of the last rotation. stall_o rises in the cycle after the period_i-th RUN cycle. period_i=0 disables the period trigger.
- R4: With mode_i=2'b01 (thermal) or 2'b10, hot_i[sel_o] sampled high in a RUN cycle starts a rotation. stall_o is high from the next cycle.
- R5: While hot_i of the resting copy (hot_i[~sel_o]) is high, no rotation starts, whatever the trigger.
- R6: Triggers that arrive while a rotation is already under way are ignored. No second rotation is queued.
- R7: stall_o and busy_o are high through every cycle of the drain, copy and switch phases, and low in RUN.
- R8: The drain phase lasts until pipe_empty_i is sampled high. From the next cycle, copy_start_o is held high until copy_done_i is sampled high.
- R9: The switch phase lasts exactly one cycle. In the cycle after it, sel_o is toggled, mig_count_o has grown by one and the period count restarts from zero.
- R10: clken_o is 2'b11 during the copy and switch phases, and equal to act_o otherwise.
- R11: shared_sel_o equals the value sel_o had one cycle earlier (0 right after reset).
- R12: mode_i=2'b11 disables both triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 periodic, 01 thermal, 10 both, 11 off |
| period_i | input | 32 | RUN cycles between periodic rotations (0 = off) |
| hot_i | input | 2 | Thermal alarm per copy |
| pipe_empty_i | input | 1 | Active copy has no work in flight |
| copy_done_i | input | 1 | State transfer finished |
| stall_o | output | 1 | Stall new issue |
| busy_o | output | 1 | Rotation under way |
| copy_start_o | output | 1 | Request state transfer from active to resting copy |
| act_o | output | 2 | One-hot active copy |
| clken_o | output | 2 | Per-copy clock enable |
| sel_o | output | 1 | Active copy index for operand routing |
| shared_sel_o | output | 1 | Select delayed one cycle for the shared unit |
| mig_count_o | output | 16 | Completed rotations |

## Verification
The period expiry and the active copy's alarm can both fire in the same RUN cycle when mode_i is 2'b10. In that same cycle the resting copy's alarm may also be high and veto both. The bench provokes this overlap with short random periods and frequent random alarms. A bench-side reference model, built from the requirements, predicts each cycle's outputs, and the bench requires exactly one rotation, or none when vetoed, with stall and select timing that matches the model.

// File: rtl/am_pkg.sv
package am_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_COPY   = 2'd2,
    ST_SWITCH = 2'd3
  } am_state_e;

  localparam logic [1:0] MODE_PERIOD  = 2'b00;
  localparam logic [1:0] MODE_THERMAL = 2'b01;
  localparam logic [1:0] MODE_BOTH    = 2'b10;
  localparam logic [1:0] MODE_OFF     = 2'b11;
endpackage

// File: rtl/am_period_timer.sv
module am_period_timer #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [PER_W-1:0] period_i,
  output logic             hit_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != '1));
    cnt_d  = clr_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = (period_i != '0) && (cnt_q >= period_i - ONE);

  p_timer_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/am_trigger.sv
module am_trigger
  import am_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       hit_i,
  input  logic [1:0] hot_i,
  input  logic       sel_i,
  output logic       req_o
);
  logic per_en, thr_en, veto;

  always_comb begin
    per_en = (mode_i == MODE_PERIOD)  || (mode_i == MODE_BOTH);
    thr_en = (mode_i == MODE_THERMAL) || (mode_i == MODE_BOTH);
    veto   = hot_i[~sel_i];
    req_o  = !veto && ((per_en && hit_i) || (thr_en && hot_i[sel_i]));
  end
endmodule

// File: rtl/am_fsm.sv
module am_fsm
  import am_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             pipe_empty_i,
  input  logic             copy_done_i,
  output am_state_e        state_o,
  output logic             sel_o,
  output logic [CNT_W-1:0] mig_o
);
  am_state_e        st_q, st_d;
  logic             sel_q;
  logic [CNT_W-1:0] mig_q;
  logic             done_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (req_i)        st_d = ST_DRAIN;
      ST_DRAIN:  if (pipe_empty_i) st_d = ST_COPY;
      ST_COPY:   if (copy_done_i)  st_d = ST_SWITCH;
      ST_SWITCH:                   st_d = ST_RUN;
      default:                     st_d = ST_RUN;
    endcase
    done_en = (st_q == ST_SWITCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      mig_q <= '0;
    end else if (done_en) begin
      sel_q <= ~sel_q;
      mig_q <= mig_q + CNT_W'(1);
    end
  end

  assign state_o = st_q;
  assign sel_o   = sel_q;
  assign mig_o   = mig_q;

  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && !pipe_empty_i) |=> (st_q == ST_DRAIN));
  p_copy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPY && !copy_done_i) |=> (st_q == ST_COPY));
  p_switch_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SWITCH) |=> (st_q == ST_RUN));
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SWITCH) |=> $stable(sel_q));
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SWITCH) |=> (mig_q == $past(mig_q) + CNT_W'(1)));
endmodule

// File: rtl/am_pingpong_ctrl.sv
module am_pingpong_ctrl
  import am_pkg::*;
#(
  parameter int PER_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [1:0]       hot_i,
  input  logic             pipe_empty_i,
  input  logic             copy_done_i,
  output logic             stall_o,
  output logic             busy_o,
  output logic             copy_start_o,
  output logic [1:0]       act_o,
  output logic [1:0]       clken_o,
  output logic             sel_o,
  output logic             shared_sel_o,
  output logic [CNT_W-1:0] mig_count_o
);
  localparam int NCOPY = 2;

  am_state_e state;
  logic      sel, hit, req, both_clk, shared_q;

  am_period_timer #(.PER_W(PER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (state == ST_RUN),
    .clr_i    (state == ST_SWITCH),
    .period_i (period_i),
    .hit_o    (hit)
  );

  am_trigger u_trig (
    .mode_i (mode_i),
    .hit_i  (hit),
    .hot_i  (hot_i),
    .sel_i  (sel),
    .req_o  (req)
  );

  am_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .pipe_empty_i (pipe_empty_i),
    .copy_done_i  (copy_done_i),
    .state_o      (state),
    .sel_o        (sel),
    .mig_o        (mig_count_o)
  );

  assign both_clk = (state == ST_COPY) || (state == ST_SWITCH);

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    assign act_o[c]   = (sel == c[0]);
    assign clken_o[c] = act_o[c] || both_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shared_q <= 1'b0;
    else        shared_q <= sel;
  end

  assign stall_o      = (state != ST_RUN);
  assign busy_o       = (state != ST_RUN);
  assign copy_start_o = (state == ST_COPY);
  assign sel_o        = sel;
  assign shared_sel_o = shared_q;

  p_act_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(act_o));
  p_idle_hot_veto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && hot_i[~sel_o]) |=> !busy_o);
  p_copy_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start_o |-> (clken_o == 2'b11));
  p_no_requeue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$stable(sel_o)) |-> 1'b0);
endmodule

// File: tb/tb_am_pingpong_ctrl.sv
module tb_am_pingpong_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [31:0] period_i;
  logic [1:0]  hot_i;
  logic        pipe_empty_i, copy_done_i;
  logic        stall_o, busy_o, copy_start_o, sel_o, shared_sel_o;
  logic [1:0]  act_o, clken_o;
  logic [15:0] mig_count_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  string ctx = "R3";

  int          m_st;
  logic        m_sel, m_seld;
  logic [31:0] m_tc;
  logic [15:0] m_mig;

  always #5 clk = ~clk;

  am_pingpong_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .period_i(period_i),
    .hot_i(hot_i), .pipe_empty_i(pipe_empty_i), .copy_done_i(copy_done_i),
    .stall_o(stall_o), .busy_o(busy_o), .copy_start_o(copy_start_o),
    .act_o(act_o), .clken_o(clken_o), .sel_o(sel_o),
    .shared_sel_o(shared_sel_o), .mig_count_o(mig_count_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit model_req(input logic [1:0] md, input logic [31:0] per,
                                   input logic [1:0] hot);
    bit pe, te, hit;
    pe  = (md == 2'b00) || (md == 2'b10);
    te  = (md == 2'b01) || (md == 2'b10);
    hit = (per != 0) && (m_tc >= per - 1);
    return !hot[~m_sel] && ((pe && hit) || (te && hot[m_sel]));
  endfunction

  task automatic compare_all();
    logic [1:0] ea, ec;
    ea = m_sel ? 2'b10 : 2'b01;
    ec = (m_st == 2 || m_st == 3) ? 2'b11 : ea;
    chk(stall_o == (m_st != 0), ctx, stall_o, m_st != 0);
    chk(busy_o == (m_st != 0), "R7", busy_o, m_st != 0);
    chk(copy_start_o == (m_st == 2), "R8", copy_start_o, m_st == 2);
    chk(act_o == ea, "R2", act_o, ea);
    chk(clken_o == ec, "R10", clken_o, ec);
    chk(sel_o == m_sel, "R9", sel_o, m_sel);
    chk(mig_count_o == m_mig, "R9", mig_count_o, m_mig);
    chk(shared_sel_o == m_seld, "R11", shared_sel_o, m_seld);
  endtask

  task automatic step(input logic [1:0] md, input logic [31:0] per, input logic [1:0] hot,
                      input logic emp, input logic dn);
    mode_i = md; period_i = per; hot_i = hot; pipe_empty_i = emp; copy_done_i = dn;
    @(posedge clk);
    m_seld = m_sel;
    case (m_st)
      0: begin
        if (model_req(md, per, hot)) m_st = 1;
        if (m_tc != 32'hFFFF_FFFF) m_tc = m_tc + 1;
      end
      1: if (emp) m_st = 2;
      2: if (dn) m_st = 3;
      default: begin
        m_st = 0; m_sel = ~m_sel; m_mig = m_mig + 1; m_tc = 0;
      end
    endcase
    @(negedge clk);
    cyc++;
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd20031));
    rst_n = 1'b0; mode_i = 2'b11; period_i = 0; hot_i = 0;
    pipe_empty_i = 0; copy_done_i = 0;
    m_st = 0; m_sel = 0; m_seld = 0; m_tc = 0; m_mig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ctx = "R1";
    compare_all();
    chk(mig_count_o == 0 && act_o == 2'b01, "R1", mig_count_o, 0);

    // periodic, directed: period 4, instant drain/copy
    ctx = "R3";
    for (int i = 0; i < 40; i++) step(2'b00, 32'd4, 2'b00, 1'b1, 1'b1);
    chk(mig_count_o >= 3, "R3", mig_count_o, 3);
    // periodic with slow drain and copy
    for (int i = 0; i < 60; i++) step(2'b00, 32'd6, 2'b00, (i % 3) == 2, (i % 4) == 3);

    // thermal: alarm on active copy only
    ctx = "R4";
    for (int i = 0; i < 40; i++)
      step(2'b01, 32'd0, (i % 10 == 0) ? (sel_o ? 2'b10 : 2'b01) : 2'b00, 1'b1, i[0]);

    // idle copy hot: vetoes both triggers
    ctx = "R5";
    for (int i = 0; i < 30; i++) step(2'b10, 32'd3, 2'b11, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(2'b10, 32'd2, sel_o ? 2'b01 : 2'b10, 1'b1, 1'b1);

    // requests during migration ignored
    ctx = "R6";
    for (int i = 0; i < 300; i++)
      step(2'b01, 32'd2, busy_o ? 2'($urandom) : 2'(($urandom % 6 == 0) ? (sel_o ? 2 : 1) : 0),
           ($urandom % 5) == 0, ($urandom % 7) == 0);

    // off mode
    ctx = "R12";
    for (int i = 0; i < 40; i++) step(2'b11, 32'd2, 2'($urandom), 1'b1, 1'b1);

    // mixed random, period and alarm overlap
    ctx = "R8";
    for (int i = 0; i < 4000; i++)
      step(2'(($urandom % 3 == 0) ? 2'b10 : (i / 500) % 4), 32'(1 + $urandom % 9),
           2'(($urandom % 4 == 0) ? $urandom : 0), ($urandom % 3) == 0, ($urandom % 3) == 0);

    // reset again mid-run
    rst_n = 1'b0;
    m_st = 0; m_sel = 0; m_seld = 0; m_tc = 0; m_mig = 0;
    @(negedge clk);
    rst_n = 1'b1;
    ctx = "R1";
    compare_all();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule